// File: doc/BRIEF.md
# Parallel CRC-8 Generator and Checker for Memory Bursts

This block produces an 8-bit cyclic redundancy code over one 64-bit data unit taken from a write or read burst of a byte-wide memory link. The whole word is folded into the code in a single clock cycle by a flattened XOR network, so the CRC and its comparison fit a tight timing budget. The generator polynomial is x^8 + x^2 + x + 1. The remainder starts from zero for every word.

An optional byte-inversion stage sits in front of the CRC. When it is enabled, any byte with mostly zero bits is inverted and marked with a per-byte flag. The CRC then covers the inverted word. In generate mode the block only returns the code. In check mode it also compares the code against the received CRC byte and raises a registered mismatch flag.

Top module: `crc8_burst_check`

## Requirements
- R1: The CRC uses polynomial x^8+x^2+x+1 (0x07), a zero start value and no final XOR. Bits are taken most-significant first: bit 63 of the word that is covered goes in first, bit 0 last. An all-zero word covered without inversion gives CRC 0.
- R2: `outValid` is high for exactly the one cycle after each cycle in which `inValid` is high, and low otherwise.
- R3: `outCrc`, `outData`, `outDbiFlags` and `mismatch` change only in the cycle after an accepted word, and keep their values until the next accepted word.
- R4: When a word is accepted with `checkMode` high, `mismatch` in the following cycle is 1 exactly when `inRxCrc` differs from the computed CRC.
- R5: When a word is accepted with `checkMode` low, `mismatch` in the following cycle is 0, whatever the value of `inRxCrc`.
- R6: With `dbiEnable` high, byte k (bits 8k+7 down to 8k) is inverted when more than 4 of its bits are 0, and flag bit k is set for it. A byte with exactly 4 zero bits is passed unchanged. `outData` shows the word after inversion, and the CRC covers that word.
- R7: With `dbiEnable` low, `outData` equals the accepted word and `outDbiFlags` is 0.
- R8: In check mode the mismatch flag is raised for every single-bit error, every double-bit error, every error with an odd number of flipped bits, and every error confined to 8 adjacent bits of the data word.
- R9: While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe: accept `inData` this cycle |
| inData | input | 64 | Data unit from the burst |
| inRxCrc | input | 8 | Received CRC byte compared in check mode |
| checkMode | input | 1 | 1 = compare against `inRxCrc`, 0 = generate only |
| dbiEnable | input | 1 | 1 = apply per-byte inversion before the CRC |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| outCrc | output | 8 | Computed CRC of the covered word |
| outData | output | 64 | Word after optional inversion |
| outDbiFlags | output | 8 | Per-byte inversion flags |
| mismatch | output | 1 | Received CRC differs from the computed CRC (check mode) |

## Verification
The assertions assume that the inputs sampled at a clock edge are known values whenever `inValid` is high, and that the mode inputs are meaningful only in that same cycle. The bench drives every input on the falling edge, so all of them are settled at the rising edge. It raises `inValid` only together with fully defined data, received CRC and mode bits. Between words it holds `inValid` low for idle gaps of varying length, so that the hold behaviour is exercised while the model predicts each cycle's outputs from a bit-serial division.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  typedef struct packed {
    logic load;
    logic check;
  } crcStrobes_t;
endpackage

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
  import crc8_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        checkMode,
  output crcStrobes_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.load  = inValid;
    strobes.check = inValid & checkMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/crc8_dbi_stage.sv
module crc8_dbi_stage #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic                      dbiEnable,
  input  logic [DATA_W-1:0]         dataIn,
  output logic [DATA_W-1:0]         dataOut,
  output logic [DATA_W/BYTE_W-1:0]  flags
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int HALF      = BYTE_W / 2;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] laneIn;
    logic              invertLane;
    assign laneIn = dataIn[b*BYTE_W +: BYTE_W];
    always_comb begin
      // zeros > HALF  <=>  ones < HALF
      invertLane = dbiEnable && ($countones(laneIn) < HALF);
    end
    assign flags[b]                      = invertLane;
    assign dataOut[b*BYTE_W +: BYTE_W]   = invertLane ? ~laneIn : laneIn;
  end
endmodule

// File: rtl/crc8_xor_net.sv
module crc8_xor_net #(
  parameter int                DATA_W = 64,
  parameter int                CRC_W  = 8,
  parameter logic [CRC_W-1:0]  POLY   = 8'h07
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);
  // Serial division used only at elaboration to derive the XOR masks.
  function automatic logic [CRC_W-1:0] serialRem(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  // Column j: which data bits feed remainder bit j (linear, zero start).
  function automatic logic [DATA_W-1:0] colMask(input int j);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] unit;
    logic [CRC_W-1:0]  rem;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      unit    = '0;
      unit[i] = 1'b1;
      rem     = serialRem(unit);
      m[i]    = rem[j];
    end
    return m;
  endfunction

  for (genvar j = 0; j < CRC_W; j++) begin : g_bit
    localparam logic [DATA_W-1:0] MASK = colMask(j);
    assign crcOut[j] = ^(dataIn & MASK);
  end
endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int                DATA_W = 64,
  parameter int                BYTE_W = 8,
  parameter int                CRC_W  = 8,
  parameter logic [CRC_W-1:0]  POLY   = 8'h07
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  crcStrobes_t               strobes,
  input  logic                      dbiEnable,
  input  logic [DATA_W-1:0]         inData,
  input  logic [CRC_W-1:0]          inRxCrc,
  output logic [CRC_W-1:0]          outCrc,
  output logic [DATA_W-1:0]         outData,
  output logic [DATA_W/BYTE_W-1:0]  outDbiFlags,
  output logic                      mismatch
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0]    coveredWord;
  logic [NUM_BYTES-1:0] laneFlags;
  logic [CRC_W-1:0]     crcNext;

  crc8_dbi_stage #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) dbiStage (
    .dbiEnable (dbiEnable),
    .dataIn    (inData),
    .dataOut   (coveredWord),
    .flags     (laneFlags)
  );

  crc8_xor_net #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) xorNet (
    .dataIn (coveredWord),
    .crcOut (crcNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCrc      <= '0;
      outData     <= '0;
      outDbiFlags <= '0;
      mismatch    <= 1'b0;
    end else if (strobes.load) begin
      outCrc      <= crcNext;
      outData     <= coveredWord;
      outDbiFlags <= laneFlags;
      mismatch    <= strobes.check && (crcNext != inRxCrc);
    end
  end

  // R1
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !dbiEnable && inData == '0) |=> (outCrc == '0));
  // R3
  hold_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(outCrc) && $stable(mismatch) &&
                       $stable(outData) && $stable(outDbiFlags)));
  // R4
  compare_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.check |=> (mismatch == ($past(inRxCrc) != outCrc)));
  // R5
  gen_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.check) |=> !mismatch);
  // R7
  dbi_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !dbiEnable) |=> (outDbiFlags == '0 && outData == $past(inData)));

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_balChk
    // R6
    dbi_balance_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.load && dbiEnable) |=>
        ($countones(outData[b*BYTE_W +: BYTE_W]) >= BYTE_W / 2));
  end
endmodule

// File: rtl/crc8_burst_check.sv
module crc8_burst_check
  import crc8_pkg::*;
#(
  parameter int                DATA_W = 64,
  parameter int                BYTE_W = 8,
  parameter int                CRC_W  = 8,
  parameter logic [CRC_W-1:0]  POLY   = 8'h07
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [DATA_W-1:0]         inData,
  input  logic [CRC_W-1:0]          inRxCrc,
  input  logic                      checkMode,
  input  logic                      dbiEnable,
  output logic                      outValid,
  output logic [CRC_W-1:0]          outCrc,
  output logic [DATA_W-1:0]         outData,
  output logic [DATA_W/BYTE_W-1:0]  outDbiFlags,
  output logic                      mismatch
);
  crcStrobes_t strobes;

  crc8_ctrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .checkMode (checkMode),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  crc8_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(POLY)) datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .dbiEnable   (dbiEnable),
    .inData      (inData),
    .inRxCrc     (inRxCrc),
    .outCrc      (outCrc),
    .outData     (outData),
    .outDbiFlags (outDbiFlags),
    .mismatch    (mismatch)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && !mismatch && outCrc == '0));
endmodule

// File: tb/crc8_burst_check_test.sv
module crc8_burst_check_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inRxCrc = '0;
  logic        checkMode = 1'b0;
  logic        dbiEnable = 1'b0;
  logic        outValid;
  logic [7:0]  outCrc;
  logic [63:0] outData;
  logic [7:0]  outDbiFlags;
  logic        mismatch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc8_burst_check uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inRxCrc(inRxCrc), .checkMode(checkMode), .dbiEnable(dbiEnable),
    .outValid(outValid), .outCrc(outCrc), .outData(outData),
    .outDbiFlags(outDbiFlags), .mismatch(mismatch)
  );

  // Bit-serial reference: MSB first, zero start, no final XOR (R1)
  function automatic logic [7:0] refCrc(input logic [63:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 63; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = (r << 1) ^ 8'h07;
      else             r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] refFlags(input logic en, input logic [63:0] d);
    logic [7:0] f = '0;
    for (int k = 0; k < 8; k++) begin
      int zeros = 0;
      for (int i = 0; i < 8; i++) if (!d[8*k+i]) zeros++;
      f[k] = en && (zeros > 4);
    end
    return f;
  endfunction

  function automatic logic [63:0] refData(input logic en, input logic [63:0] d);
    logic [63:0] o = d;
    logic [7:0]  f = refFlags(en, d);
    for (int k = 0; k < 8; k++) if (f[k]) o[8*k +: 8] = ~d[8*k +: 8];
    return o;
  endfunction

  // Cycle model
  logic        expValid = 0, expMis = 0;
  logic [7:0]  expCrc = '0, expFlags = '0;
  logic [63:0] expData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 0; expMis <= 0; expCrc <= '0; expFlags <= '0; expData <= '0;
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expData  <= refData(dbiEnable, inData);
        expFlags <= refFlags(dbiEnable, inData);
        expCrc   <= refCrc(refData(dbiEnable, inData));
        expMis   <= checkMode && (refCrc(refData(dbiEnable, inData)) != inRxCrc);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(outValid === expValid, "R2", "outValid", 64'(outValid), 64'(expValid));
      check(outCrc === expCrc, "R1", "outCrc", 64'(outCrc), 64'(expCrc));
      check(outData === expData, "R6", "outData", outData, expData);
      check(outDbiFlags === expFlags, "R6", "outDbiFlags", 64'(outDbiFlags), 64'(expFlags));
      check(mismatch === expMis, "R4", "mismatch", 64'(mismatch), 64'(expMis));
    end
  end

  task automatic sendWord(input logic [63:0] d, input logic [7:0] rx,
                          input logic chk, input logic dbi);
    @(negedge clk);
    inValid = 1; inData = d; inRxCrc = rx; checkMode = chk; dbiEnable = dbi;
    @(negedge clk);
    inValid = 0; inData = $urandom(); inRxCrc = 8'($urandom());
    checkMode = 1'($urandom()); dbiEnable = 1'($urandom());
  endtask

  task automatic expectError(input logic [63:0] base, input logic [63:0] flip, input string what);
    sendWord(base ^ flip, refCrc(base), 1'b1, 1'b0);
    check(mismatch === 1'b1, "R8", what, 64'(mismatch), 64'd1);
  endtask

  initial begin
    logic [7:0]  heldCrc;
    logic [63:0] base;
    repeat (3) @(negedge clk);
    // R9: reset values
    check(outValid === 0 && mismatch === 0 && outCrc === 0 && outData === 0 && outDbiFlags === 0,
          "R9", "reset outputs", {outCrc, outDbiFlags, 47'd0, outValid}, 64'd0);
    rstN = 1;

    // R1: zero word gives zero code
    sendWord(64'd0, 8'h00, 1'b0, 1'b0);
    check(outCrc === 8'h00, "R1", "zero word crc", 64'(outCrc), 64'd0);
    // R1: single set bits at both ends
    sendWord(64'h8000_0000_0000_0000, 8'h00, 1'b0, 1'b0);
    check(outCrc === refCrc(64'h8000_0000_0000_0000), "R1", "msb word crc", 64'(outCrc),
          64'(refCrc(64'h8000_0000_0000_0000)));
    sendWord(64'h1, 8'h00, 1'b0, 1'b0);
    check(outCrc === 8'h07, "R1", "lsb word crc", 64'(outCrc), 64'h07);

    // R3: results hold through idle cycles
    sendWord(64'hDEAD_BEEF_0123_4567, 8'h00, 1'b1, 1'b0);
    heldCrc = outCrc;
    repeat (4) @(negedge clk);
    check(outCrc === heldCrc && outValid === 0, "R3", "held crc", 64'(outCrc), 64'(heldCrc));

    // R4: compare correct and wrong received code
    sendWord(64'hCAFE_F00D_5555_AAAA, refCrc(64'hCAFE_F00D_5555_AAAA), 1'b1, 1'b0);
    check(mismatch === 0, "R4", "match", 64'(mismatch), 64'd0);
    sendWord(64'hCAFE_F00D_5555_AAAA, ~refCrc(64'hCAFE_F00D_5555_AAAA), 1'b1, 1'b0);
    check(mismatch === 1, "R4", "mismatch", 64'(mismatch), 64'd1);

    // R5: generate mode ignores wrong received code
    sendWord(64'h1234_5678_9ABC_DEF0, ~refCrc(64'h1234_5678_9ABC_DEF0), 1'b0, 1'b0);
    check(mismatch === 0, "R5", "gen mode flag", 64'(mismatch), 64'd0);

    // R6: inversion thresholds
    sendWord(64'h00FF_0F01_071F_3CE0, 8'h00, 1'b0, 1'b1);
    check(outDbiFlags === 8'h99, "R6", "dbi flags", 64'(outDbiFlags), 64'h99);
    check(outData === 64'hFFFF_0FFE_F81F_3C1F, "R6", "dbi data", outData, 64'hFFFF_0FFE_F81F_3C1F);
    check(outCrc === refCrc(64'hFFFF_0FFE_F81F_3C1F), "R6", "crc over inverted", 64'(outCrc),
          64'(refCrc(64'hFFFF_0FFE_F81F_3C1F)));

    // R7: inversion disabled
    sendWord(64'h00FF_0F01_071F_3CE0, 8'h00, 1'b0, 1'b0);
    check(outDbiFlags === 8'h00 && outData === 64'h00FF_0F01_071F_3CE0, "R7", "dbi off data",
          outData, 64'h00FF_0F01_071F_3CE0);

    // R8: injected errors
    base = 64'h0F1E_2D3C_4B5A_6978;
    expectError(base, 64'h1, "single bit 0");
    expectError(base, 64'h20_0000_0000, "single bit 37");
    expectError(base, 64'h8000_0000_0000_0000, "single bit 63");
    expectError(base, 64'h8000_0000_0000_0001, "double 0,63");
    expectError(base, 64'h60, "double 5,6");
    expectError(base, 64'h0004_0000_0000_1000, "double 12,50");
    expectError(base, 64'h0100_0000_0100_0001, "odd three");
    expectError(base, 64'h1010_0101_0000_1000, "odd five");
    expectError(base, 64'hFF, "burst at 0");
    expectError(base, 64'hFF << 17, "burst at 17");
    expectError(base, 64'hFF << 56, "burst at 56");
    expectError(base, 64'h81 << 20, "burst ends at 20");
    expectError(base, 64'hA5 << 40, "burst pattern at 40");

    // Mixed traffic with random gaps; model checks every cycle
    for (int n = 0; n < 40; n++) begin
      logic [63:0] d = {$urandom(), $urandom()};
      logic        dbi = 1'($urandom());
      logic [7:0]  rx = (n % 3 == 0) ? 8'($urandom()) : refCrc(refData(dbi, d));
      sendWord(d, rx, 1'($urandom()), dbi);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    // Back-to-back words
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      inValid = 1; inData = {$urandom(), $urandom()}; inRxCrc = 8'($urandom());
      checkMode = 1; dbiEnable = 1'(n);
    end
    @(negedge clk);
    inValid = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule